// File: doc/BRIEF.md
# DDR Burst SRAM Front End

This block is the synchronous front end of a pipelined, double-data-rate SRAM that moves data in fixed bursts of four words. Each burst spans two primary clock cycles and carries one word per clock edge. Commands are sampled once per primary cycle: a word address, an active-low load strobe and a read/write select. Write bursts are held in a late-write buffer and only reach the storage array when the next write burst completes. Reads stay coherent with that buffer, so a read always returns the newest value written to its address.

Both clock edges are modelled with one internal clock running at twice the primary rate. A phase bit records which edge of the primary pair each internal edge stands for, so every register in the block sits on a single clock. The storage is a behavioural register array of parameterised depth. Addresses wider than the implemented depth alias modulo that depth. Read data leaves through a register stage together with an output-enable flag that stands in for the tristate control of a shared bus.

Top module: `ddr_burst_sram_ctrl`

## Requirements
- R1: While reset is held and after it is released with no command, `rdata_oe` is 0, `rdata` is 0 and `kphase` is 0.
- R2: `kphase` alternates 0,1,0,1 on successive `clk2x` edges after reset. 0 means the coming edge is a primary rising edge (K) and 1 means it is a complement edge (K#). `ld_n`, `rw_n` and `addr` are sampled only on K edges, and a low `ld_n` on a K# edge starts nothing.
- R3: A burst accepted on K edge L performs exactly four beats, on the `clk2x` edges L+1, L+2, L+3 and L+4.
- R4: Beat b of a burst loaded with address A uses word address {A[ADDR_W-1:2], (A[1:0]+b) mod 4}.
- R5: In a write burst (`rw_n`=0), `wdata` is captured on every beat edge, K# and K edges alike, and the word is stored at that beat's address.
- R6: In a read burst (`rw_n`=1), the word for beat b is on `rdata` with `rdata_oe`=1 during the `clk2x` period after beat edge L+1+b. This is a latency of one internal clock from the load edge to the first word.
- R7: A low `ld_n` on the K edge in the middle of a burst (beat 1) is ignored. The burst runs on unchanged and no new burst starts from that request.
- R8: A load on the K edge of a burst's last beat is accepted, so the next burst's beats follow with no gap.
- R9: A read returns the most recently written value for each address. This holds while that value still sits in the late-write buffer, including a read loaded on the last beat edge of the write.
- R10: Only the low MEM_AW bits of a word address select storage; addresses that differ only above them name the same word.
- R11: On the first `clk2x` edge with no read beat, `rdata_oe` falls to 0. `rdata` is 0 whenever `rdata_oe` is 0.
- R12: Two write bursts to the same words followed by a read return the second burst's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Internal clock at twice the primary rate; each rising edge is one K or K# edge |
| rst_n | input | 1 | Active-low reset |
| ld_n | input | 1 | Active-low burst load request, sampled on K edges |
| rw_n | input | 1 | 1 = read burst, 0 = write burst, sampled with the load |
| addr | input | ADDR_W | Starting word address of the burst |
| wdata | input | DATA_W | Write word, captured on each write beat edge |
| rdata | output | DATA_W | Registered read word, 0 when not enabled |
| rdata_oe | output | 1 | Read data valid / output enable |
| kphase | output | 1 | 0 = next clk2x edge is a K edge, 1 = a K# edge |

## Verification
On every cycle the assertions check the edge alternation, that a burst starts only from a K-edge load, the unbroken beat count, the linear wrap of the low address bits, the tie between output enable and a read beat on the previous edge, and the quiet data bus when disabled. Data values are beyond them. Coherence through the late-write buffer, newest-wins ordering, aliasing above the array depth and the exact word on each beat can only be shown by the bench's scenarios. There a behavioural model tracks memory contents per address and predicts every output edge.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

    // Position of a word inside a four-word burst.
    typedef logic [1:0] beat_t;

    // Which edge of the primary clock pair the next internal edge stands for.
    typedef enum logic {
        PH_K  = 1'b0,
        PH_KN = 1'b1
    } phase_e;

    localparam int BURST_WORDS = 4;

    // Linear burst order: low address bits advance from the start and wrap.
    function automatic beat_t burst_lo(beat_t start, beat_t beat);
        return beat_t'(start + beat);
    endfunction

endpackage

// File: rtl/ddrb_seq.sv
module ddrb_seq
    import ddrb_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    output phase_e            phase,
    output logic              busy,
    output logic              rd,
    output logic              last,
    output beat_t             beat,
    output beat_t             lo,
    output logic [ADDR_W-3:0] base
);

    typedef struct packed {
        phase_e            phase;
        logic              busy;
        logic              rd;
        beat_t             beat;
        beat_t             start;
        logic [ADDR_W-3:0] base;
    } seq_t;

    seq_t s_q, s_d;
    logic accept;

    always_comb begin
        s_d       = s_q;
        s_d.phase = (s_q.phase == PH_K) ? PH_KN : PH_K;
        last      = s_q.busy && (s_q.beat == beat_t'(BURST_WORDS - 1));

        // Advance the running burst by one beat per internal edge.
        if (s_q.busy) begin
            s_d.beat = beat_t'(s_q.beat + 2'd1);
            if (last) begin
                s_d.busy = 1'b0;
            end
        end

        // A load is honoured on K edges when idle or on the final beat.
        accept = !ld_n && (s_q.phase == PH_K) && (!s_q.busy || last);
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.rd    = rw_n;
            s_d.beat  = '0;
            s_d.start = addr[1:0];
            s_d.base  = addr[ADDR_W-1:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.phase;
    assign busy  = s_q.busy;
    assign rd    = s_q.rd;
    assign beat  = s_q.beat;
    assign lo    = burst_lo(s_q.start, s_q.beat);
    assign base  = s_q.base;

endmodule

// File: rtl/ddrb_wbuf.sv
module ddrb_wbuf
    import ddrb_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ROW_W  = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                beat_en,
    input  logic                                last,
    input  beat_t                               lo,
    input  logic [ROW_W-1:0]                    row,
    input  logic [DATA_W-1:0]                   wdata,
    output logic                                commit_we,
    output logic [ROW_W-1:0]                    commit_row,
    output logic [BURST_WORDS-1:0][DATA_W-1:0]  commit_data,
    output logic                                fwd_hit,
    output logic [BURST_WORDS-1:0][DATA_W-1:0]  fwd_data
);

    typedef struct packed {
        logic [BURST_WORDS-1:0][DATA_W-1:0] stage;
        logic [BURST_WORDS-1:0][DATA_W-1:0] pend;
        logic [ROW_W-1:0]                   pend_row;
        logic                               pend_valid;
    } wbuf_t;

    wbuf_t b_q, b_d;

    always_comb begin
        b_d       = b_q;
        commit_we = 1'b0;
        if (beat_en) begin
            if (last) begin
                // Older pending burst retires; the finished one takes its place.
                commit_we        = b_q.pend_valid;
                b_d.pend         = b_q.stage;
                b_d.pend[lo]     = wdata;
                b_d.pend_row     = row;
                b_d.pend_valid   = 1'b1;
            end else begin
                b_d.stage[lo] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign commit_row  = b_q.pend_row;
    assign commit_data = b_q.pend;
    assign fwd_hit     = b_q.pend_valid && (b_q.pend_row == row);
    assign fwd_data    = b_q.pend;

endmodule

// File: rtl/ddrb_bank.sv
module ddrb_bank #(
    parameter int DATA_W = 36,
    parameter int ROW_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ROW_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROW_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ddr_burst_sram_ctrl.sv
module ddr_burst_sram_ctrl
    import ddrb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 36,
    parameter int MEM_AW = 8
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              kphase
);

    localparam int ROW_W  = MEM_AW - 2;
    localparam int BASE_W = ADDR_W - 2;

    phase_e            seq_phase;
    logic              seq_busy;
    logic              seq_rd;
    logic              seq_last;
    beat_t             seq_beat;
    beat_t             seq_lo;
    logic [BASE_W-1:0] seq_base;
    logic [ROW_W-1:0]  row;

    ddrb_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk   (clk2x),
        .rst_n (rst_n),
        .ld_n  (ld_n),
        .rw_n  (rw_n),
        .addr  (addr),
        .phase (seq_phase),
        .busy  (seq_busy),
        .rd    (seq_rd),
        .last  (seq_last),
        .beat  (seq_beat),
        .lo    (seq_lo),
        .base  (seq_base)
    );

    assign row = seq_base[ROW_W-1:0];

    // Address bits above the implemented depth alias onto the same words.
    generate
        if (MEM_AW < ADDR_W) begin : g_alias
            logic unused_hi_bits;
            assign unused_hi_bits = ^seq_base[BASE_W-1:ROW_W];
        end
    endgenerate

    logic                               commit_we;
    logic [ROW_W-1:0]                   commit_row;
    logic [BURST_WORDS-1:0][DATA_W-1:0] commit_data;
    logic                               fwd_hit;
    logic [BURST_WORDS-1:0][DATA_W-1:0] fwd_data;
    logic [BURST_WORDS-1:0][DATA_W-1:0] bank_rd;

    ddrb_wbuf #(
        .DATA_W (DATA_W),
        .ROW_W  (ROW_W)
    ) u_wbuf (
        .clk         (clk2x),
        .rst_n       (rst_n),
        .beat_en     (seq_busy && !seq_rd),
        .last        (seq_last),
        .lo          (seq_lo),
        .row         (row),
        .wdata       (wdata),
        .commit_we   (commit_we),
        .commit_row  (commit_row),
        .commit_data (commit_data),
        .fwd_hit     (fwd_hit),
        .fwd_data    (fwd_data)
    );

    // One bank per low-address value: a whole burst retires in one edge.
    generate
        for (genvar g = 0; g < BURST_WORDS; g++) begin : g_bank
            ddrb_bank #(
                .DATA_W (DATA_W),
                .ROW_W  (ROW_W)
            ) u_bank (
                .clk   (clk2x),
                .rst_n (rst_n),
                .we    (commit_we),
                .waddr (commit_row),
                .wdata (commit_data[g]),
                .raddr (row),
                .rdata (bank_rd[g])
            );
        end
    endgenerate

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d = '0;
        if (seq_busy && seq_rd) begin
            o_d.oe   = 1'b1;
            o_d.data = fwd_hit ? fwd_data[seq_lo] : bank_rd[seq_lo];
        end
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rdata    = o_q.data;
    assign rdata_oe = o_q.oe;
    assign kphase   = (seq_phase == PH_KN);

endmodule

// File: rtl/ddrb_chk.sv
module ddrb_chk
    import ddrb_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              phase_kn,
    input logic              busy,
    input logic              rd,
    input beat_t             beat,
    input beat_t             lo,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe
);

    AST_K_THEN_KN: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_kn |=> phase_kn);                                          // R2
    AST_KN_THEN_K: assert property (@(posedge clk) disable iff (!rst_n)
        phase_kn |=> !phase_kn);                                          // R2
    AST_START_FROM_K_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat == 2'd0) |-> ($past(!phase_kn) && $past(!ld_n)));  // R2
    AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat != 2'd3) |=> (busy && beat == beat_t'($past(beat) + 2'd1))); // R7
    AST_LINEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat != 2'd0) |-> (lo == beat_t'($past(lo) + 2'd1)));   // R4
    AST_OE_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe == $past(busy && rd));                                   // R6
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));                                     // R11

endmodule

bind ddr_burst_sram_ctrl ddrb_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk2x),
    .rst_n    (rst_n),
    .ld_n     (ld_n),
    .phase_kn (kphase),
    .busy     (seq_busy),
    .rd       (seq_rd),
    .beat     (seq_beat),
    .lo       (seq_lo),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/ddr_burst_sram_ctrl_tb.sv
module ddr_burst_sram_ctrl_tb;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 36;
    localparam int MEM_AW = 8;
    localparam int DEPTH  = 1 << MEM_AW;

    logic              clk2x = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_n  = 1'b1;
    logic              rw_n  = 1'b1;
    logic [ADDR_W-1:0] addr  = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_oe;
    logic              kphase;

    always #2 clk2x = ~clk2x;

    ddr_burst_sram_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MEM_AW (MEM_AW)
    ) u_dut (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .ld_n     (ld_n),
        .rw_n     (rw_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rdata_oe (rdata_oe),
        .kphase   (kphase)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state: plain integers and an associative memory.
    int edge_cnt = 0;
    int m_busy = 0, m_rd = 0, m_base = 0, m_start = 0, m_beat = 0;
    logic [DATA_W-1:0] ref_mem [int];

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Drive one clk2x edge, predict its outputs, and compare after the edge.
    task automatic step(bit l, bit r, int unsigned a, string tag);
        logic [DATA_W-1:0] d, exp_d;
        bit exp_oe, acc;
        int lo, key;
        d     = {4'($urandom), 32'($urandom)};
        ld_n  = l;
        rw_n  = r;
        addr  = ADDR_W'(a);
        wdata = d;
        chk({tag, " kphase"}, DATA_W'(kphase), DATA_W'(edge_cnt % 2));
        exp_oe = 1'b0;
        exp_d  = '0;
        acc = (edge_cnt % 2 == 0) && !l && (m_busy == 0 || m_beat == 3);
        if (m_busy != 0) begin
            lo  = (m_start + m_beat) % 4;
            key = (m_base * 4 + lo) % DEPTH;
            if (m_rd != 0) begin
                exp_oe = 1'b1;
                exp_d  = ref_mem.exists(key) ? ref_mem[key] : '0;
            end else begin
                ref_mem[key] = d;
            end
            m_beat++;
            if (m_beat == 4) m_busy = 0;
        end
        if (acc) begin
            m_busy  = 1;
            m_rd    = r;
            m_base  = int'(a) / 4;
            m_start = int'(a) % 4;
            m_beat  = 0;
        end
        edge_cnt++;
        @(posedge clk2x);
        #1;
        chk({tag, " oe"}, DATA_W'(rdata_oe), DATA_W'(exp_oe));
        chk({tag, " data"}, rdata, exp_d);
        @(negedge clk2x);
    endtask

    // One primary cycle: K edge carries the command, K# edge has ld_n high.
    task automatic kc(bit l, bit r, int unsigned a, string tag);
        step(l, r, a, tag);
        step(1'b1, r, a, tag);
    endtask

    task automatic burst(bit r, int unsigned a, string tag);
        kc(1'b0, r, a, tag);
        kc(1'b1, r, a, tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) kc(1'b1, 1'b1, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk2x);
        n_bad++;
        $display("FAIL R3 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk2x);
        @(negedge clk2x);
        // R1: quiet outputs while reset is held.
        chk("R1 reset oe", DATA_W'(rdata_oe), '0);
        chk("R1 reset data", rdata, '0);
        chk("R1 reset kphase", DATA_W'(kphase), '0);
        rst_n = 1'b1;
        idle(2, "R1");

        burst(1'b0, 'h10, "R5");          // write, start 0
        burst(1'b1, 'h10, "R9");          // read from late-write buffer, back to back
        burst(1'b1, 'h12, "R4");          // wrapped order from start 2
        burst(1'b0, 'h21, "R3");          // second write retires the first
        burst(1'b1, 'h11, "R6");          // read from banks
        idle(2, "R11");

        // R2: load strobe on a K# edge only.
        step(1'b1, 1'b1, 'h10, "R2");
        step(1'b0, 1'b1, 'h10, "R2");
        idle(2, "R2");

        // R7: mid-burst load ignored.
        kc(1'b0, 1'b1, 'h10, "R7");
        kc(1'b0, 1'b1, 'h20, "R7");
        kc(1'b1, 1'b1, 0, "R7");
        idle(2, "R7");

        // R8: back-to-back reads on last-beat edges.
        burst(1'b1, 'h13, "R8");
        burst(1'b1, 'h22, "R8");
        burst(1'b1, 'h10, "R8");
        idle(1, "R11");

        // R10: address aliasing above the implemented depth.
        burst(1'b0, 'h510, "R10");
        idle(1, "R10");
        burst(1'b1, 'h10, "R10");
        burst(1'b0, 'h34, "R10");
        burst(1'b1, 'h3_0512, "R10");
        idle(1, "R10");

        // R12: two writes to the same words, newest wins.
        burst(1'b0, 'h30, "R12");
        burst(1'b0, 'h32, "R12");
        burst(1'b1, 'h31, "R12");
        burst(1'b0, 'h44, "R12");
        burst(1'b1, 'h33, "R12");
        idle(2, "R11");

        // Mixed traffic across a small address window.
        for (int i = 0; i < 400; i++) begin
            int unsigned sel, a;
            sel = $urandom % 5;
            a   = ($urandom % 48) + (($urandom % 4) << MEM_AW);
            if (sel == 0) idle(1, "R9");
            else          burst(sel[0], a, "R9");
        end
        idle(3, "R11");

        summary();
        $finish;
    end

endmodule